// File: doc/BRIEF.md
# Seven-to-One Video Lane Serializer

This block turns a 35-bit parallel pixel word into five serial data lanes plus a forwarded clock lane. Each word is typically three 10-bit colour components and five sync or control bits. On every pixel clock a word is captured on the edge chosen by a select pin. Each 7-bit slice of the word is then shifted out, one bit per slot, during the next pixel period. The serial side runs on a bit clock at seven times the pixel rate, which the surrounding chip provides from its clock multiplier.

The receiver uses the clock lane to find each 7-slot frame: the lane runs high for four slots and low for three. When the active-low power-down pin is held low, all serial outputs are parked and the output-enable, which models the high-impedance state, is dropped. When the pin is released, the block waits a programmable number of pixel clocks for the multiplier to settle. It then turns the outputs back on at the start of a frame.

Top module: `lvds7_serializer`

## Requirements
- R1: Lane k (k = 0..4) is driven on `ser_data[k]` and carries input bits `pix_data[7k+6 : 7k]`; lane bit b is `pix_data[7k+b]`.
- R2: Within a frame each lane sends bit 6 first, then bits 5, 4, 3, 2, 1 and 0, one bit per bit-clock cycle.
- R3: A frame lasts exactly 7 bit clocks. A slot counter runs 0 to 6 and wraps to 0, and frames follow each other with no gap while the pixel clock runs.
- R4: The clock lane sends the slot pattern 1,1,0,0,0,1,1. Its first high slot coincides with the bit-6 slot of the data lanes.
- R5: With `edge_rise` high the word is captured on the rising pixel-clock edge; with it low, on the falling edge.
- R6: The first slot of a frame begins less than one pixel period after the word it carries was captured.
- R7: While `drv_en` is low, all serial outputs are 0. Driving `pwr_dn_n` low drops `drv_en` at once.
- R8: After `pwr_dn_n` rises, `drv_en` stays low for at least `LOCK_CYCLES` pixel clocks and rises within `LOCK_CYCLES`+5 pixel clocks. It rises only when the multiplier-lock indication has crossed into the bit domain, and only on slot 0.
- R9: After `edge_rise` changes, correct back-to-back frames resume within 3 pixel periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pix_clk | input | 1 | Pixel clock |
| bit_clk | input | 1 | Serial bit clock, 7 times the pixel clock, phase-locked to it |
| pwr_dn_n | input | 1 | Active-low power-down; also the asynchronous reset |
| edge_rise | input | 1 | Capture edge select: 1 rising, 0 falling |
| pix_data | input | 35 | Parallel pixel word |
| ser_data | output | 5 | Serial data lanes, lane k on bit k |
| ser_clk | output | 1 | Forwarded clock lane |
| drv_en | output | 1 | Output-enable; low models high-impedance outputs |

## Verification
The bench changes the input word every half pixel period, so a rising-edge capture and a falling-edge capture see different words and a wrong capture edge shows up as a frame mismatch. Walking-one and walking-zero words place every input bit alone in every lane and slot. This exposes any swapped lane, reversed slot order or stuck bit. A hashed word sequence then catches faults that depend on neighbouring bits. Frames are recovered from the clock-lane pattern alone. They are checked for content, spacing and capture-to-slot latency across edge changes and power-down/relock cycles, where the enable window is measured against its lower and upper bounds.

// File: rtl/lvds7_pkg.sv
package lvds7_pkg;

  // Level of the forwarded clock lane in a given slot: low for a run of
  // nslots/2 slots starting at slot 2, high elsewhere (1100011 for 7).
  function automatic logic clk_slot_high(input int slot, input int nslots);
    return !((slot >= 2) && (slot < 2 + nslots / 2));
  endfunction

  // Slot counter successor with wrap.
  function automatic int next_slot(input int slot, input int nslots);
    return (slot >= nslots - 1) ? 0 : slot + 1;
  endfunction

endpackage

// File: rtl/lvds7_rst_sync.sv
module lvds7_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/lvds7_capture.sv
module lvds7_capture #(
  parameter int WORD_W = 35
) (
  input  logic              pix_clk,
  input  logic              rst_p_n,
  input  logic              edge_rise,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] word_out,
  output logic              tog_out
);
  logic [WORD_W-1:0] cap_r, cap_f;
  logic              tog_r, tog_f;

  // rising-edge capture path, active only when selected
  always_ff @(posedge pix_clk or negedge rst_p_n) begin
    if (!rst_p_n) begin
      cap_r <= '0;
      tog_r <= 1'b0;
    end else if (edge_rise) begin
      cap_r <= din;
      tog_r <= ~tog_r;
    end
  end

  // falling-edge capture path, active only when selected
  always_ff @(negedge pix_clk or negedge rst_p_n) begin
    if (!rst_p_n) begin
      cap_f <= '0;
      tog_f <= 1'b0;
    end else if (!edge_rise) begin
      cap_f <= din;
      tog_f <= ~tog_f;
    end
  end

  assign word_out = edge_rise ? cap_r : cap_f;
  assign tog_out  = edge_rise ? tog_r : tog_f;
endmodule

// File: rtl/lvds7_lock_timer.sv
module lvds7_lock_timer #(
  parameter int LOCK_CYCLES = 16
) (
  input  logic pix_clk,
  input  logic rst_p_n,
  output logic locked
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge pix_clk or negedge rst_p_n) begin
    if (!rst_p_n) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (!locked) begin
      if (cnt == CNT_W'(LOCK_CYCLES - 1)) locked <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lvds7_bit_core.sv
module lvds7_bit_core
  import lvds7_pkg::*;
#(
  parameter int LANES  = 5,
  parameter int SLOTS  = 7,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic                   bit_clk,
  input  logic                   rst_b_n,
  input  logic [LANES*SLOTS-1:0] word_in,
  input  logic                   tog_in,
  input  logic                   lock_in,
  output logic [LANES-1:0]       ser_data,
  output logic                   ser_clk,
  output logic                   drv_en,
  output logic                   frame_load,
  output logic [SLOT_W-1:0]      slot_cnt,
  output logic                   lock_bit
);
  localparam int WORD_W = LANES * SLOTS;

  logic              tog_s1, tog_s2, tog_s3;
  logic              lock_s1, lock_s2;
  logic              reload;
  logic              en_r;
  logic [WORD_W-1:0] hold_word;
  logic [WORD_W-1:0] src_word;
  logic [SLOTS-1:0]  pat_init;
  logic [SLOTS-1:0]  pat;
  logic [LANES-1:0]  lane_bit;

  // double-register handoff of the capture toggle and the lock flag
  always_ff @(posedge bit_clk or negedge rst_b_n) begin
    if (!rst_b_n) begin
      tog_s1  <= 1'b0;
      tog_s2  <= 1'b0;
      tog_s3  <= 1'b0;
      lock_s1 <= 1'b0;
      lock_s2 <= 1'b0;
    end else begin
      tog_s1  <= tog_in;
      tog_s2  <= tog_s1;
      tog_s3  <= tog_s2;
      lock_s1 <= lock_in;
      lock_s2 <= lock_s1;
    end
  end

  assign frame_load = tog_s2 ^ tog_s3;
  assign lock_bit   = lock_s2;
  assign reload     = frame_load | (slot_cnt == SLOT_W'(SLOTS - 1));

  always_ff @(posedge bit_clk or negedge rst_b_n) begin
    if (!rst_b_n)        slot_cnt <= '0;
    else if (frame_load) slot_cnt <= '0;
    else                 slot_cnt <= SLOT_W'(next_slot(int'(slot_cnt), SLOTS));
  end

  always_ff @(posedge bit_clk or negedge rst_b_n) begin
    if (!rst_b_n)        hold_word <= '0;
    else if (frame_load) hold_word <= word_in;
  end

  // a wrap without a new word repeats the last one
  assign src_word = frame_load ? word_in : hold_word;

  // clock-lane pattern, MSB is slot 0
  for (genvar s = 0; s < SLOTS; s++) begin : g_pat
    assign pat_init[SLOTS-1-s] = clk_slot_high(s, SLOTS);
  end

  always_ff @(posedge bit_clk or negedge rst_b_n) begin
    if (!rst_b_n)    pat <= '0;
    else if (reload) pat <= pat_init;
    else             pat <= {pat[SLOTS-2:0], 1'b0};
  end

  // one shifter per lane, bit SLOTS-1 leaves first
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] sh;
    always_ff @(posedge bit_clk or negedge rst_b_n) begin
      if (!rst_b_n)    sh <= '0;
      else if (reload) sh <= src_word[l*SLOTS +: SLOTS];
      else             sh <= {sh[SLOTS-2:0], 1'b0};
    end
    assign lane_bit[l] = sh[SLOTS-1];
  end

  // outputs turn on only at a frame start once lock has crossed over
  always_ff @(posedge bit_clk or negedge rst_b_n) begin
    if (!rst_b_n)                   en_r <= 1'b0;
    else if (frame_load && lock_s2) en_r <= 1'b1;
  end

  assign drv_en   = en_r;
  assign ser_data = en_r ? lane_bit : '0;
  assign ser_clk  = en_r & pat[SLOTS-1];
endmodule

// File: rtl/lvds7_serializer.sv
module lvds7_serializer #(
  parameter int LANES       = 5,
  parameter int SLOTS       = 7,
  parameter int LOCK_CYCLES = 16
) (
  input  logic                   pix_clk,
  input  logic                   bit_clk,
  input  logic                   pwr_dn_n,
  input  logic                   edge_rise,
  input  logic [LANES*SLOTS-1:0] pix_data,
  output logic [LANES-1:0]       ser_data,
  output logic                   ser_clk,
  output logic                   drv_en
);
  localparam int WORD_W = LANES * SLOTS;
  localparam int SLOT_W = $clog2(SLOTS);

  logic              rst_p_n;
  logic              rst_b_n;
  logic [WORD_W-1:0] cap_word;
  logic              cap_tog;
  logic              pix_locked;
  logic              frame_load;
  logic [SLOT_W-1:0] slot_cnt;
  logic              lock_bit;

  lvds7_rst_sync #(.STAGES(2)) u_rst_pix (
    .clk    (pix_clk),
    .arst_n (pwr_dn_n),
    .srst_n (rst_p_n)
  );

  lvds7_rst_sync #(.STAGES(2)) u_rst_bit (
    .clk    (bit_clk),
    .arst_n (pwr_dn_n),
    .srst_n (rst_b_n)
  );

  lvds7_capture #(.WORD_W(WORD_W)) u_capture (
    .pix_clk   (pix_clk),
    .rst_p_n   (rst_p_n),
    .edge_rise (edge_rise),
    .din       (pix_data),
    .word_out  (cap_word),
    .tog_out   (cap_tog)
  );

  lvds7_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .pix_clk (pix_clk),
    .rst_p_n (rst_p_n),
    .locked  (pix_locked)
  );

  lvds7_bit_core #(
    .LANES  (LANES),
    .SLOTS  (SLOTS),
    .SLOT_W (SLOT_W)
  ) u_core (
    .bit_clk    (bit_clk),
    .rst_b_n    (rst_b_n),
    .word_in    (cap_word),
    .tog_in     (cap_tog),
    .lock_in    (pix_locked),
    .ser_data   (ser_data),
    .ser_clk    (ser_clk),
    .drv_en     (drv_en),
    .frame_load (frame_load),
    .slot_cnt   (slot_cnt),
    .lock_bit   (lock_bit)
  );
endmodule

// File: rtl/lvds7_serializer_chk.sv
module lvds7_serializer_chk #(
  parameter int LANES  = 5,
  parameter int SLOTS  = 7,
  parameter int SLOT_W = 3
) (
  input logic              bit_clk,
  input logic              rst_b_n,
  input logic [SLOT_W-1:0] slot_cnt,
  input logic              frame_load,
  input logic              lock_bit,
  input logic              drv_en,
  input logic [LANES-1:0]  ser_data,
  input logic              ser_clk
);

  AST_SLOT_RANGE: assert property (@(posedge bit_clk) disable iff (!rst_b_n)
    slot_cnt < SLOT_W'(SLOTS)); // R3

  AST_SLOT_ADVANCE: assert property (@(posedge bit_clk) disable iff (!rst_b_n)
    (!frame_load && slot_cnt != SLOT_W'(SLOTS - 1)) |=> (slot_cnt == $past(slot_cnt) + 1'b1)); // R3

  AST_CLK_FIRST_HIGH: assert property (@(posedge bit_clk) disable iff (!rst_b_n)
    (drv_en && slot_cnt == '0) |-> ser_clk); // R4

  AST_CLK_MID_LOW: assert property (@(posedge bit_clk) disable iff (!rst_b_n)
    (drv_en && slot_cnt == SLOT_W'(2)) |-> !ser_clk); // R4

  AST_QUIET_OFF: assert property (@(posedge bit_clk) disable iff (!rst_b_n)
    !drv_en |-> (ser_data == '0 && !ser_clk)); // R7

  AST_EN_NEEDS_LOCK: assert property (@(posedge bit_clk) disable iff (!rst_b_n)
    drv_en |-> lock_bit); // R8

  AST_EN_AT_FRAME: assert property (@(posedge bit_clk) disable iff (!rst_b_n)
    $rose(drv_en) |-> (slot_cnt == '0)); // R8

endmodule

bind lvds7_serializer lvds7_serializer_chk #(
  .LANES  (LANES),
  .SLOTS  (SLOTS),
  .SLOT_W (SLOT_W)
) chk_i (
  .bit_clk    (bit_clk),
  .rst_b_n    (rst_b_n),
  .slot_cnt   (slot_cnt),
  .frame_load (frame_load),
  .lock_bit   (lock_bit),
  .drv_en     (drv_en),
  .ser_data   (ser_data),
  .ser_clk    (ser_clk)
);

// File: tb/lvds7_serializer_tb.sv
`timescale 1ns/1ps
module lvds7_serializer_tb_top;
  localparam int LANES = 5;
  localparam int SLOTS = 7;
  localparam int LOCK  = 16;
  localparam int W     = LANES * SLOTS;
  localparam longint PIX_T = 28;  // 7 bit periods of 4 ns

  logic          pix_clk, bit_clk, pwr_dn_n, edge_rise;
  logic [W-1:0]  pix_data;
  logic [LANES-1:0] ser_data;
  logic          ser_clk, drv_en;

  int checks = 0, failures = 0;
  int frames = 0, quiet_err = 0, first_bad = 0, first_cnt = 0;
  bit skip = 0, first_seen = 0;

  lvds7_serializer #(.LANES(LANES), .SLOTS(SLOTS), .LOCK_CYCLES(LOCK)) dut_i (
    .pix_clk(pix_clk), .bit_clk(bit_clk), .pwr_dn_n(pwr_dn_n), .edge_rise(edge_rise),
    .pix_data(pix_data), .ser_data(ser_data), .ser_clk(ser_clk), .drv_en(drv_en));

  initial bit_clk = 0;
  always #2 bit_clk = ~bit_clk;
  initial pix_clk = 0;
  always #14 pix_clk = ~pix_clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // word stream: walking one, walking zero, then hashed; odd halves inverted
  function automatic logic [W-1:0] gen_word(input int n);
    int j;
    logic [63:0] b;
    j = n >> 1;
    if (j < W)          b = 64'd1 << j;
    else if (j < 2 * W) b = ~(64'd1 << (j - W));
    else                b = (64'(j) * 64'h9E3779B97F4A7C15) ^ (64'(j) << 23);
    if (n[0]) b = ~b;
    return b[W-1:0];
  endfunction

  initial begin
    int n;
    n = 0;
    pix_data = '0;
    #7;
    forever begin
      pix_data = gen_word(n);
      n++;
      #14;
    end
  end

  // bench model of the capture (R5)
  logic [W-1:0] cur_w = '0, prev_w = '0;
  longint cur_t = 0, prev_t = 0;
  always @(pix_clk) begin
    if ((pix_clk && edge_rise) || (!pix_clk && !edge_rise)) begin
      prev_w = cur_w; prev_t = cur_t;
      cur_w = pix_data; cur_t = $time;
    end
  end

  // deserializer locked to the clock-lane pattern
  logic [6:0] h_clk;
  logic [LANES-1:0][6:0] h_dat;
  longint last_ft = -1;
  always @(negedge bit_clk) begin
    if (!drv_en) begin
      if (ser_data != '0 || ser_clk) quiet_err++;
      h_clk = '0; h_dat = '0; last_ft = -1; first_seen = 0;
    end else begin
      if (!first_seen) begin
        first_seen = 1; first_cnt++;
        if (!ser_clk) first_bad++;
      end
      h_clk = {h_clk[5:0], ser_clk};
      for (int l = 0; l < LANES; l++) h_dat[l] = {h_dat[l][5:0], ser_data[l]};
      if (h_clk == 7'b1100011) begin
        logic [W-1:0] w, ew;
        longint ts, et;
        for (int l = 0; l < LANES; l++)
          for (int b = 0; b < SLOTS; b++) w[l*SLOTS + b] = h_dat[l][b];
        ts = $time - 24;
        if (cur_t <= ts) begin ew = cur_w; et = cur_t; end
        else             begin ew = prev_w; et = prev_t; end
        if (!skip) begin
          chk(w == ew, "R1 R2 R5 frame content", 64'(w), 64'(ew));
          chk((ts - 2 - et) > 0 && (ts - 2 - et) < PIX_T, "R6 capture-to-slot latency",
              64'(ts - 2 - et), 64'(PIX_T));
          if (last_ft >= 0) chk(($time - last_ft) == PIX_T, "R3 frame spacing",
                                64'($time - last_ft), 64'(PIX_T));
          last_ft = $time;
          frames++;
        end else last_ft = -1;
      end
    end
  end

  task automatic release_and_lock();
    @(posedge pix_clk);
    #10;
    pwr_dn_n = 1;
    #(LOCK * PIX_T);
    chk(!drv_en, "R8 enable too early", 64'(drv_en), 0);
    #(5 * PIX_T);
    chk(drv_en, "R8 enable too late", 64'(drv_en), 1);
  endtask

  initial begin
    #(200000 * 4);
    chk(0, "R3 watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    pwr_dn_n = 0;
    edge_rise = 1;
    #100;
    @(negedge bit_clk);
    chk(!drv_en, "R7 reset enable", 64'(drv_en), 0);
    chk(ser_data == '0 && !ser_clk, "R7 reset outputs", 64'({ser_clk, ser_data}), 0);

    // rising-edge capture
    release_and_lock();
    frames = 0;
    #(150 * PIX_T);
    chk(frames >= 140, "R3 R5 frames on rising edge", 64'(frames), 140);

    // switch to falling-edge capture
    skip = 1; edge_rise = 0;
    #(3 * PIX_T);
    skip = 0; frames = 0;
    #(150 * PIX_T);
    chk(frames >= 145, "R9 frames after edge change", 64'(frames), 145);

    // power-down during traffic
    #5;
    pwr_dn_n = 0;
    @(negedge bit_clk);
    chk(!drv_en, "R7 power-down enable", 64'(drv_en), 0);
    chk(ser_data == '0 && !ser_clk, "R7 power-down outputs", 64'({ser_clk, ser_data}), 0);
    #(10 * PIX_T);
    release_and_lock();
    frames = 0;
    #(60 * PIX_T);
    chk(frames >= 55, "R8 frames after relock", 64'(frames), 55);

    // back to rising-edge capture
    skip = 1; edge_rise = 1;
    #(3 * PIX_T);
    skip = 0; frames = 0;
    #(60 * PIX_T);
    chk(frames >= 55, "R9 frames after second edge change", 64'(frames), 55);

    chk(quiet_err == 0, "R7 outputs quiet while disabled", 64'(quiet_err), 0);
    chk(first_bad == 0 && first_cnt == 2, "R4 first enabled slot is clock high",
        64'(first_bad), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule